// File: doc/BRIEF.md
# Value-to-Unary Pulse Stream Serializer

This block turns a small multi-cycle measurement, such as the cycle count of a memory access or the length of a pipeline stall, into a fixed-length serial bit stream. The number of ones in each frame equals the measured value. A downstream probability estimator can therefore read the fraction of ones as the value divided by the frame length. For example, three ones in a four-bit frame read as 75 percent, and 100 percent means the range maximum.

Each sample picks one of two frame lengths: a short range of 0 to 4 with a 4-bit frame, or a long range of 0 to 16 with a 16-bit frame. The range can change from one sample to the next. The set bits are spread evenly across the frame instead of being packed into a thermometer code, which lowers the variance of the counter downstream.

Samples may arrive at any time, with no alignment to the consumer. A sample that arrives while a frame is being shifted out waits in a one-entry holding slot. A later arrival replaces the waiting sample.

Top module: `unary_stream_ser`

## Requirements
- R1: After a synchronous active-high reset, `ser_valid` and `ser_bit` are both 0.
- R2: A sample taken with `range_long`=0 produces a frame of exactly 4 valid bits, and the number of ones in it equals the sample value.
- R3: A sample taken with `range_long`=1 produces a frame of exactly 16 valid bits, and the number of ones in it equals the sample value.
- R4: For value v and frame length N, frame bit i (i = 0 first on the wire, up to N-1) is 1 exactly when floor((i+1)*v/N) differs from floor(i*v/N).
- R5: A value above the selected range maximum (4 or 16) is treated as that maximum, so the frame is all ones.
- R6: When no frame is active, a sample strobed at a clock edge has its bit 0 on `ser_bit`, with `ser_valid`=1, right after that edge. Each later bit follows one clock later.
- R7: A sample that arrives during a frame starts on the clock right after that frame's last bit, so `ser_valid` stays high with no gap.
- R8: If a second sample arrives while one is already waiting, the newer one replaces it. The replaced sample never appears on the output.
- R9: While no frame is active, `ser_valid` is 0 and `ser_bit` is 0.
- R10: The range is captured with each sample, so consecutive frames may alternate between lengths 4 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_value | input | 5 | Measured value to encode |
| smp_valid | input | 1 | One-cycle strobe that accepts `smp_value` and `range_long` |
| range_long | input | 1 | 0 selects the 4-bit frame, 1 selects the 16-bit frame |
| ser_bit | output | 1 | Serial frame bit |
| ser_valid | output | 1 | High while `ser_bit` carries a frame bit |

## Verification
When the block is idle, bit 0 of a frame is due one clock after the edge that takes the strobe. The bits that follow are due one per clock, and a waiting sample's bit 0 is due on the clock after the previous frame's last bit. The bench drives inputs and samples outputs on the falling edge. A monitor compares each valid bit with the head of a queue of expected bits, so any shift in timing shows up as a mismatch. A run-length counter on `ser_valid` confirms that two queued frames arrive back to back with no idle cycle between them. A check inside the sample task confirms that `ser_valid` is already high at the first falling edge after an idle strobe.

// File: rtl/unary_ser_pkg.sv
package unary_ser_pkg;

    localparam int SHORT_LEN = 4;
    localparam int LONG_LEN  = 16;
    localparam int MAX_LEN   = (SHORT_LEN > LONG_LEN) ? SHORT_LEN : LONG_LEN;
    localparam int VAL_W     = $clog2(MAX_LEN + 1);
    localparam int IDX_W     = $clog2(MAX_LEN);
    localparam int N_RANGES  = 2;

    typedef enum logic {
        RNG_SHORT = 1'b0,
        RNG_LONG  = 1'b1
    } rng_e;

    typedef struct packed {
        logic [MAX_LEN-1:0] bits;
        logic [IDX_W-1:0]   len_m1;
        logic [VAL_W-1:0]   ones;
    } frame_t;

    function automatic int range_len(input int sel);
        return (sel == 0) ? SHORT_LEN : LONG_LEN;
    endfunction

    function automatic logic [VAL_W-1:0] clamp_val(input logic [VAL_W-1:0] v, input int n);
        return (int'(v) > n) ? VAL_W'(n) : v;
    endfunction

    // Even spread: bit i is set when the running share of v crosses an integer
    function automatic logic [MAX_LEN-1:0] spread_bits(input logic [VAL_W-1:0] v, input int n);
        logic [MAX_LEN-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (i < n) begin
                r[i] = (((i + 1) * int'(v)) / n) != ((i * int'(v)) / n);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ser_frame_build.sv
module ser_frame_build
    import unary_ser_pkg::*;
(
    input  logic [VAL_W-1:0] value,
    input  logic             sel_long,
    output frame_t           frame
);
    frame_t cand [N_RANGES];

    for (genvar g = 0; g < N_RANGES; g++) begin : g_range
        localparam int LEN = range_len(g);
        logic [VAL_W-1:0] v_cl;
        always_comb begin
            v_cl           = clamp_val(value, LEN);
            cand[g].ones   = v_cl;
            cand[g].len_m1 = IDX_W'(LEN - 1);
            cand[g].bits   = spread_bits(v_cl, LEN);
        end
    end

    always_comb begin
        frame = sel_long ? cand[1] : cand[0];
    end
endmodule

// File: rtl/ser_hold_slot.sv
module ser_hold_slot
    import unary_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  frame_t wr_frame,
    input  logic   clr,
    output logic   full,
    output frame_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            held <= wr_frame;
        end else if (clr) begin
            full <= 1'b0;
        end
    end

    // R8
    overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (full && held == $past(wr_frame)));
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
    import unary_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t load_frame,
    output logic   active,
    output logic   last,
    output logic   ser_bit
);
    logic [MAX_LEN-1:0] sh_bits;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   len_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_bits <= '0;
            idx     <= '0;
            len_m1  <= '0;
            active  <= 1'b0;
        end else if (load) begin
            sh_bits <= load_frame.bits;
            idx     <= '0;
            len_m1  <= load_frame.len_m1;
            active  <= 1'b1;
        end else if (active) begin
            if (last) begin
                active  <= 1'b0;
                sh_bits <= '0;
            end else begin
                sh_bits <= sh_bits >> 1;
                idx     <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        last    = active && (idx == len_m1);
        ser_bit = active && sh_bits[0];
    end

    // R6
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (active && idx == '0));

    // R2
    ones_match_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> ($countones(load_frame.bits) == int'(load_frame.ones)));

    // R9
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !load) |=> (!active && !ser_bit));
endmodule

// File: rtl/unary_stream_ser.sv
module unary_stream_ser
    import unary_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] smp_value,
    input  logic             smp_valid,
    input  logic             range_long,
    output logic             ser_bit,
    output logic             ser_valid
);
    frame_t in_frame;
    frame_t slot_frame;
    frame_t load_frame;
    logic   slot_full;
    logic   sh_active;
    logic   sh_last;
    logic   free;
    logic   load;
    logic   slot_wr;
    logic   slot_clr;

    ser_frame_build u_build (
        .value    (smp_value),
        .sel_long (range_long),
        .frame    (in_frame)
    );

    always_comb begin
        free       = !sh_active || sh_last;
        load       = free && (slot_full || smp_valid);
        load_frame = slot_full ? slot_frame : in_frame;
        slot_wr    = smp_valid && (!free || slot_full);
        slot_clr   = free && slot_full;
    end

    ser_hold_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (slot_wr),
        .wr_frame (in_frame),
        .clr      (slot_clr),
        .full     (slot_full),
        .held     (slot_frame)
    );

    ser_shift_core u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_frame (load_frame),
        .active     (sh_active),
        .last       (sh_last),
        .ser_bit    (ser_bit)
    );

    assign ser_valid = sh_active;

    // R5
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (int'(in_frame.ones) <= (range_long ? LONG_LEN : SHORT_LEN)));

    // R7
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_last && slot_full) |=> ser_valid);
endmodule

// File: tb/unary_stream_ser_tb.sv
`timescale 1ns/1ps
module unary_stream_ser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] smp_value = '0;
    logic       smp_valid = 1'b0;
    logic       range_long = 1'b0;
    logic       ser_bit;
    logic       ser_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int run_len = 0;
    int max_run = 0;
    bit mon_on  = 1'b0;

    typedef struct { bit b; int req; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    unary_stream_ser u_dut (
        .clk(clk), .rst(rst), .smp_value(smp_value), .smp_valid(smp_valid),
        .range_long(range_long), .ser_bit(ser_bit), .ser_valid(ser_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Expected frame per R4/R5, pushed tagged with the range requirement
    task automatic push_frame(input int v, input bit lng);
        int n;
        int vc;
        int ones;
        n    = lng ? 16 : 4;
        vc   = (v > n) ? n : v;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.b = (((i + 1) * vc) / n) != ((i * vc) / n);
            e.req = lng ? 3 : 2;
            ones += int'(e.b);
            q.push_back(e);
        end
        // sanity of bench model against R2/R3 counting rule
        if (ones != vc) $display("model mismatch v=%0d", v);
    endtask

    // Driver: strobe a sample for one cycle, optionally queue its bits
    task automatic send(input int v, input bit lng, input bit push, input bit from_idle);
        @(negedge clk);
        smp_value  = 5'(v);
        range_long = lng;
        smp_valid  = 1'b1;
        if (push) push_frame(v, lng);
        @(negedge clk);
        smp_valid = 1'b0;
        // R6: bit 0 due right after the strobe edge when idle
        if (from_idle) check(ser_valid == 1'b1, "R6", int'(ser_valid), 1);
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while ((ser_valid || q.size() != 0) && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(t < 200, "R6", t, 0);
        @(negedge clk);
    endtask

    // Monitor: pop and compare each valid bit
    always @(negedge clk) begin
        if (mon_on) begin
            if (ser_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (q.size() == 0) begin
                    check(1'b0, "R8", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    n_chk++;
                    if (ser_bit != e.b) begin
                        n_fail++;
                        $display("FAIL R%0d/R4 bit actual=%0d expected=%0d at %0t",
                                 e.req, ser_bit, e.b, $time);
                    end
                end
            end else begin
                run_len = 0;
                // R9: bit is quiet outside frames
                check(ser_bit == 1'b0, "R9", int'(ser_bit), 0);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(ser_valid == 1'b0, "R1", int'(ser_valid), 0);
        check(ser_bit == 1'b0, "R1", int'(ser_bit), 0);
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        // R2, R4: all short-range values
        for (int v = 0; v <= 4; v++) begin
            send(v, 1'b0, 1'b1, 1'b1);
            wait_idle();
        end
        // R3, R4: all long-range values
        for (int v = 0; v <= 16; v++) begin
            send(v, 1'b1, 1'b1, 1'b1);
            wait_idle();
        end
        // R5: clamping in both ranges
        send(7, 1'b0, 1'b1, 1'b1);
        wait_idle();
        send(31, 1'b1, 1'b1, 1'b1);
        wait_idle();
        send(17, 1'b1, 1'b1, 1'b1);
        wait_idle();

        // R7, R10: long frame with short sample queued behind it, no gap
        max_run = 0;
        send(5, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        send(2, 1'b0, 1'b1, 1'b0);
        wait_idle();
        check(max_run == 20, "R7", max_run, 20);

        // R8: waiting sample replaced by a newer one
        max_run = 0;
        send(9, 1'b1, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        send(1, 1'b0, 1'b0, 1'b0);
        send(4, 1'b0, 1'b1, 1'b0);
        wait_idle();
        check(max_run == 20, "R8", max_run, 20);

        // R10: alternate ranges, short then long queued
        max_run = 0;
        send(3, 1'b0, 1'b1, 1'b1);
        send(11, 1'b1, 1'b1, 1'b0);
        wait_idle();
        check(max_run == 20, "R10", max_run, 20);

        // R9: idle after all frames
        check(ser_valid == 1'b0, "R9", int'(ser_valid), 0);
        check(q.size() == 0, "R8", q.size(), 0);

        // R1: mid-frame reset clears the shifter
        mon_on = 1'b0;
        send(16, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(ser_valid == 1'b0, "R1", int'(ser_valid), 0);
        check(ser_bit == 1'b0, "R1", int'(ser_bit), 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule